// File: doc/BRIEF.md
# Video Test Pattern Generator

This block drives a raster display with synthetic test images. A horizontal and a vertical counter scan an active area (1024 by 768 pixels at a 65 MHz pixel clock by default) framed by front porch, sync and back porch intervals. Every pixel clock the block presents one 24-bit RGB value together with active-low horizontal sync, active-low vertical sync and a blank flag. Every interval length is a parameter.

Software programs the image through a small Wishbone slave register bank. It sets an enable bit, the image kind (horizontal stripes, vertical stripes or a checkerboard), a rectangular window, a stripe width, a per-stripe colour increment and a base colour. Pixels outside the window are black. Each stripe's colour is the previous stripe's colour plus the increment, with each byte wrapping on its own.

The settings in use are never the bus registers themselves. At the last pixel of each frame the timing counter raises a frame request. At that request a working copy takes the bus register values, but only if the register bank reports its contents as valid. The bank withdraws that flag during a write strobe and for the rest of any bus cycle that carried a write. A multi-register update made inside one bus cycle therefore reaches the screen whole, at a frame boundary, or not at all in that frame.

Top module: `vid_pattern_gen`

## Requirements
- R1: While rst_ni is low the outputs are rgb_o = 0, hsync_o = 1, vsync_o = 1, blank_o = 1 and wb_ack_o = 0. Every register resets to zero, so the first frame is black.
- R2: Registers are selected by wb_adr_i. Address 0 is control: bit 0 enable, bits 2:1 kind (0 horizontal stripes, 1 vertical stripes, 2 or 3 checkerboard). Address 1 is the column window: start in bits 15:0, exclusive end in bits 31:16. Address 2 is the row window in the same layout. Address 3 is the stripe width in bits 15:0. Address 4 is the colour increment and address 5 is the base colour, both with red in 23:16, green in 15:8 and blue in 7:0. Unused bits and addresses 6 and 7 read as zero, and writes to them are dropped. wb_dat_o shows the addressed register combinationally. wb_ack_o goes high for exactly one cycle, one clock after an accepted strobe.
- R3: A frame is H_ACTIVE+H_FP+H_SYNC+H_BP pixels by V_ACTIVE+V_FP+V_SYNC+V_BP lines, scanned in raster order. After reset release, clock edge n presents pixel n-1. hsync_o is low on pixels H_ACTIVE+H_FP to H_ACTIVE+H_FP+H_SYNC-1 of every line. vsync_o is low on every pixel of lines V_ACTIVE+V_FP to V_ACTIVE+V_FP+V_SYNC-1. blank_o is high outside the active area.
- R4: The register-valid flag is low during any write strobe and stays low until wb_cyc_i falls after a write.
- R5: The working settings are reloaded from the registers only on the edge that presents the last pixel of a frame, and only if register-valid is high at that edge. They govern the frame that starts on the next edge. Otherwise the previous settings are kept.
- R6: In horizontal-stripe mode a pixel in the window on row y takes base + k*increment, where k = (y - row start) / width.
- R7: In vertical-stripe mode the same rule applies with k = (x - column start) / width.
- R8: In checkerboard mode a pixel in the window takes the base colour when kx + ky is even and base + increment when it is odd. Here kx and ky are the column and row stripe indices.
- R9: Pixels outside the window are black, and a window whose end is not greater than its start shows nothing. With enable at 0 every pixel is black.
- R10: rgb_o is zero whenever blank_o is high.
- R11: A stripe width of 0 behaves as width 1. Each colour byte wraps modulo 256 independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel and bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Register word address |
| wb_dat_i | input | 32 | Write data |
| wb_ack_o | output | 1 | Transfer acknowledge |
| wb_dat_o | output | 32 | Read data |
| rgb_o | output | 24 | Pixel colour, red in 23:16 |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| blank_o | output | 1 | High outside the active area |

## Verification
The risky overlap is a register write that lands on the same edge as the frame request. Two cases are provoked. In the first, a strobe lands exactly on the last pixel of a frame. In the second, a bus cycle opens with a write two pixels before the frame end and is held open across the boundary. The bench reference model tracks the bus registers, the valid flag and the working settings on its own, and predicts every output on every clock. Showing the old image for one more frame and then the new one with no mixed frame is therefore judged pixel by pixel.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  localparam int CW = 16;  // coordinate field width
  localparam int PW = 24;  // pixel colour width

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_XWIN  = 3'd1;
  localparam logic [2:0] ADR_YWIN  = 3'd2;
  localparam logic [2:0] ADR_WIDTH = 3'd3;
  localparam logic [2:0] ADR_STEP  = 3'd4;
  localparam logic [2:0] ADR_BASE  = 3'd5;

  typedef enum logic [1:0] {
    KIND_HLINES = 2'd0,
    KIND_VCOLS  = 2'd1,
    KIND_CHECK  = 2'd2,
    KIND_CHECK2 = 2'd3
  } vpg_kind_e;

  typedef struct packed {
    logic          enable;
    vpg_kind_e     kind;
    logic [CW-1:0] x0;
    logic [CW-1:0] x1;
    logic [CW-1:0] y0;
    logic [CW-1:0] y1;
    logic [CW-1:0] width;
    logic [PW-1:0] step;
    logic [PW-1:0] base;
  } vpg_cfg_t;

  function automatic logic [PW-1:0] rgb_add(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PW-1:0] s;
    for (int c = 0; c < 3; c++) s[c*8 +: 8] = a[c*8 +: 8] + b[c*8 +: 8];
    return s;
  endfunction
endpackage

// File: rtl/vpg_wb_regs.sv
module vpg_wb_regs
  import vpg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [2:0]  wb_adr_i,
  input  logic [31:0] wb_dat_i,
  output logic        wb_ack_o,
  output logic [31:0] wb_dat_o,
  output vpg_cfg_t    cfg_o,
  output logic        reg_valid_o
);
  logic          ack_q, busy_q;
  logic [2:0]    ctrl_q;
  logic [31:0]   xwin_q, ywin_q;
  logic [CW-1:0] width_q;
  logic [PW-1:0] step_q, base_q;
  logic          wr_en;

  assign wr_en = wb_cyc_i && wb_stb_i && wb_we_i && !ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      busy_q  <= 1'b0;
      ctrl_q  <= '0;
      xwin_q  <= '0;
      ywin_q  <= '0;
      width_q <= '0;
      step_q  <= '0;
      base_q  <= '0;
    end else begin
      ack_q  <= wb_cyc_i && wb_stb_i && !ack_q;
      // busy spans the rest of any bus cycle that wrote
      busy_q <= wb_cyc_i ? (busy_q || (wb_stb_i && wb_we_i)) : 1'b0;
      if (wr_en) begin
        unique case (wb_adr_i)
          ADR_CTRL:  ctrl_q  <= wb_dat_i[2:0];
          ADR_XWIN:  xwin_q  <= wb_dat_i;
          ADR_YWIN:  ywin_q  <= wb_dat_i;
          ADR_WIDTH: width_q <= wb_dat_i[CW-1:0];
          ADR_STEP:  step_q  <= wb_dat_i[PW-1:0];
          ADR_BASE:  base_q  <= wb_dat_i[PW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    wb_dat_o = '0;
    unique case (wb_adr_i)
      ADR_CTRL:  wb_dat_o = {29'd0, ctrl_q};
      ADR_XWIN:  wb_dat_o = xwin_q;
      ADR_YWIN:  wb_dat_o = ywin_q;
      ADR_WIDTH: wb_dat_o = {16'd0, width_q};
      ADR_STEP:  wb_dat_o = {8'd0, step_q};
      ADR_BASE:  wb_dat_o = {8'd0, base_q};
      default:   wb_dat_o = '0;
    endcase
  end

  assign wb_ack_o    = ack_q;
  assign reg_valid_o = !busy_q && !(wb_cyc_i && wb_stb_i && wb_we_i);

  always_comb begin
    cfg_o        = '0;
    cfg_o.enable = ctrl_q[0];
    cfg_o.kind   = vpg_kind_e'(ctrl_q[2:1]);
    cfg_o.x0     = xwin_q[15:0];
    cfg_o.x1     = xwin_q[31:16];
    cfg_o.y0     = ywin_q[15:0];
    cfg_o.y1     = ywin_q[31:16];
    cfg_o.width  = width_q;
    cfg_o.step   = step_q;
    cfg_o.base   = base_q;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o); // R2
  AST_VALID_HELD_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_i && $past(wb_cyc_i) && $past(wb_stb_i && wb_we_i)) |-> !reg_valid_o); // R4
endmodule

// File: rtl/vpg_timing.sv
module vpg_timing #(
  parameter int H_ACTIVE = 1024,
  parameter int H_FP     = 24,
  parameter int H_SYNC   = 136,
  parameter int H_BP     = 160,
  parameter int V_ACTIVE = 768,
  parameter int V_FP     = 3,
  parameter int V_SYNC   = 6,
  parameter int V_BP     = 29,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic [HW-1:0] h_nxt_o,
  output logic [VW-1:0] v_nxt_o,
  output logic          line_wrap_o,
  output logic          frame_req_o,
  output logic          active_o,
  output logic          hsync_n_o,
  output logic          vsync_n_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT  = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACTIVE + V_FP + V_SYNC);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          h_last, v_last;

  assign h_last      = (h_q == H_LAST);
  assign v_last      = (v_q == V_LAST);
  assign h_nxt_o     = h_last ? '0 : h_q + 1'b1;
  assign v_nxt_o     = h_last ? (v_last ? '0 : v_q + 1'b1) : v_q;
  assign line_wrap_o = h_last;
  assign frame_req_o = h_last && v_last;
  assign h_o         = h_q;
  assign v_o         = v_q;
  assign active_o    = (h_q < H_ACT) && (v_q < V_ACT);
  assign hsync_n_o   = !((h_q >= HS_BEG) && (h_q < HS_END));
  assign vsync_n_o   = !((v_q >= VS_BEG) && (v_q < VS_END));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_nxt_o;
      v_q <= v_nxt_o;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_req_o |=> (h_o == '0 && v_o == '0)); // R3
endmodule

// File: rtl/vpg_stripe.sv
module vpg_stripe
  import vpg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [CW-1:0] pos_nxt_i,
  input  logic [CW-1:0] origin_i,
  input  logic [CW-1:0] width_i,
  input  logic [PW-1:0] base_i,
  input  logic [PW-1:0] step_i,
  output logic [PW-1:0] col_o,
  output logic          par_o
);
  logic [CW-1:0] cnt_q, w_last;
  logic [PW-1:0] col_q;
  logic          par_q;

  assign w_last = (width_i == '0) ? '0 : width_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      col_q <= '0;
      par_q <= 1'b0;
    end else if (adv_i) begin
      if (pos_nxt_i <= origin_i) begin
        // before or at the window origin: hold the first stripe
        cnt_q <= '0;
        col_q <= base_i;
        par_q <= 1'b0;
      end else if (cnt_q >= w_last) begin
        cnt_q <= '0;
        col_q <= rgb_add(col_q, step_i);
        par_q <= !par_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign col_o = col_q;
  assign par_o = par_q;

  AST_STRIPE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (pos_nxt_i <= origin_i)) |=> (cnt_q == '0 && !par_q)); // R6
endmodule

// File: rtl/vid_pattern_gen.sv
module vid_pattern_gen
  import vpg_pkg::*;
#(
  parameter int H_ACTIVE = 1024,
  parameter int H_FP     = 24,
  parameter int H_SYNC   = 136,
  parameter int H_BP     = 160,
  parameter int V_ACTIVE = 768,
  parameter int V_FP     = 3,
  parameter int V_SYNC   = 6,
  parameter int V_BP     = 29
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [2:0]  wb_adr_i,
  input  logic [31:0] wb_dat_i,
  output logic        wb_ack_o,
  output logic [31:0] wb_dat_o,
  output logic [23:0] rgb_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        blank_o
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  vpg_cfg_t      cfg_bus, cfg_nxt, shadow_q;
  logic          reg_valid, frame_req, line_wrap, active, hs_n, vs_n;
  logic [HW-1:0] h, h_nxt;
  logic [VW-1:0] v, v_nxt;
  logic [PW-1:0] s_col [2];
  logic          s_par [2];
  logic [CW-1:0] hx, vy;
  logic          in_win;
  logic [PW-1:0] pix;

  vpg_wb_regs u_regs (
    .clk_i, .rst_ni, .wb_cyc_i, .wb_stb_i, .wb_we_i, .wb_adr_i, .wb_dat_i,
    .wb_ack_o, .wb_dat_o, .cfg_o(cfg_bus), .reg_valid_o(reg_valid)
  );

  vpg_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk_i, .rst_ni, .h_o(h), .v_o(v), .h_nxt_o(h_nxt), .v_nxt_o(v_nxt),
    .line_wrap_o(line_wrap), .frame_req_o(frame_req), .active_o(active),
    .hsync_n_o(hs_n), .vsync_n_o(vs_n)
  );

  // settings for the frame that begins after this edge
  assign cfg_nxt = (frame_req && reg_valid) ? cfg_bus : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else         shadow_q <= cfg_nxt;
  end

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    vpg_stripe u_stripe (
      .clk_i, .rst_ni,
      .adv_i     ((ax == 0) ? 1'b1 : line_wrap),
      .pos_nxt_i ((ax == 0) ? CW'(h_nxt) : CW'(v_nxt)),
      .origin_i  ((ax == 0) ? cfg_nxt.x0 : cfg_nxt.y0),
      .width_i   (cfg_nxt.width),
      .base_i    (cfg_nxt.base),
      .step_i    (cfg_nxt.step),
      .col_o     (s_col[ax]),
      .par_o     (s_par[ax])
    );
  end

  assign hx     = CW'(h);
  assign vy     = CW'(v);
  assign in_win = (hx >= shadow_q.x0) && (hx < shadow_q.x1) &&
                  (vy >= shadow_q.y0) && (vy < shadow_q.y1);

  always_comb begin
    unique case (shadow_q.kind)
      KIND_HLINES: pix = s_col[1];
      KIND_VCOLS:  pix = s_col[0];
      default:     pix = (s_par[0] ^ s_par[1]) ? rgb_add(shadow_q.base, shadow_q.step)
                                               : shadow_q.base;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o   <= '0;
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
      blank_o <= 1'b1;
    end else begin
      rgb_o   <= (active && shadow_q.enable && in_win) ? pix : '0;
      hsync_o <= hs_n;
      vsync_o <= vs_n;
      blank_o <= !active;
    end
  end

  AST_BLANK_BLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (rgb_o == '0)); // R10
  AST_HSYNC_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> blank_o); // R3
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_req |=> $stable(shadow_q)); // R5
  AST_SHADOW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_req && reg_valid) |=> (shadow_q == $past(cfg_bus))); // R5
endmodule

// File: tb/vid_pattern_gen_bench.sv
module vid_pattern_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 16, HF = 2, HS = 3, HB = 3;
  localparam int VA = 12, VF = 1, VS = 2, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int TOT = HT * VT;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [2:0]  adr = '0;
  logic [31:0] dat = '0;
  logic        ack, hs_o, vs_o, blank;
  logic [31:0] rdat;
  logic [23:0] rgb;

  int n_cmp = 0, n_bad = 0;
  bit checking = 1'b0, done = 1'b0;

  vid_pattern_gen #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) u_vid_pattern_gen (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat), .wb_ack_o(ack), .wb_dat_o(rdat),
    .rgb_o(rgb), .hsync_o(hs_o), .vsync_o(vs_o), .blank_o(blank)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model state
  int          m_pos;
  logic [31:0] m_regs [6];
  logic [31:0] m_shadow [6];
  logic        m_busy, m_ack;
  logic [23:0] e_rgb;
  logic        e_hs, e_vs, e_blank, e_ack;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h exp %0h at pos %0d", tag, got, exp, m_pos);
    end
  endtask

  function automatic logic [31:0] mask_reg(int a, logic [31:0] d);
    case (a)
      0: return {29'd0, d[2:0]};
      3: return {16'd0, d[15:0]};
      4, 5: return {8'd0, d[23:0]};
      default: return d;
    endcase
  endfunction

  // R6 R7 R8 R9 R11: stripe index by division, colour by modular sum
  function automatic logic [23:0] exp_pix(int h, int v);
    logic [23:0] r;
    int x0, x1, y0, y1, w, kx, ky, k, kind;
    r  = '0;
    x0 = int'(m_shadow[1][15:0]);  x1 = int'(m_shadow[1][31:16]);
    y0 = int'(m_shadow[2][15:0]);  y1 = int'(m_shadow[2][31:16]);
    if (m_shadow[0][0] && h >= x0 && h < x1 && v >= y0 && v < y1) begin
      w    = (m_shadow[3][15:0] == 0) ? 1 : int'(m_shadow[3][15:0]);
      kx   = (h - x0) / w;
      ky   = (v - y0) / w;
      kind = int'(m_shadow[0][2:1]);
      k    = (kind == 0) ? ky : (kind == 1) ? kx : (kx + ky) % 2;
      for (int c = 0; c < 3; c++)
        r[c*8 +: 8] = 8'((int'(m_shadow[5][c*8 +: 8]) + k * int'(m_shadow[4][c*8 +: 8])) % 256);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_busy = 0; m_ack = 0;
      for (int i = 0; i < 6; i++) begin m_regs[i] = '0; m_shadow[i] = '0; end
      e_rgb = '0; e_hs = 1; e_vs = 1; e_blank = 1; e_ack = 0;
    end else begin
      automatic int h = m_pos % HT;
      automatic int v = m_pos / HT;
      automatic logic valid = !m_busy && !(cyc && stb && we);
      e_blank = !(h < HA && v < VA);
      e_rgb   = e_blank ? 24'd0 : exp_pix(h, v);
      e_hs    = !(h >= HA + HF && h < HA + HF + HS);
      e_vs    = !(v >= VA + VF && v < VA + VF + VS);
      if (m_pos == TOT - 1 && valid)
        for (int i = 0; i < 6; i++) m_shadow[i] = m_regs[i];
      if (cyc && stb && we && !m_ack && adr < 6) m_regs[adr] = mask_reg(int'(adr), dat);
      m_busy = cyc ? (m_busy || (stb && we)) : 1'b0;
      m_ack  = cyc && stb && !m_ack;
      e_ack  = m_ack;
      m_pos  = (m_pos + 1) % TOT;
    end
  end

  always @(negedge clk) begin
    if (checking && rst_n) begin
      check("R5 R6 R7 R8 R9 R10 R11 rgb", {8'd0, rgb}, {8'd0, e_rgb});
      check("R3 hsync", {31'd0, hs_o}, {31'd0, e_hs});
      check("R3 vsync", {31'd0, vs_o}, {31'd0, e_vs});
      check("R3 blank", {31'd0, blank}, {31'd0, e_blank});
      check("R2 ack", {31'd0, ack}, {31'd0, e_ack});
    end
  end

  // caller is at a negedge
  task automatic wb_write(logic [2:0] a, logic [31:0] d, bit keep_cyc);
    cyc = 1; stb = 1; we = 1; adr = a; dat = d;
    @(negedge clk);
    stb = 0; we = 0;
    if (!keep_cyc) cyc = 0;
    @(negedge clk);
  endtask

  task automatic wb_read_check(logic [2:0] a, logic [31:0] exp, string tag);
    cyc = 1; stb = 1; we = 0; adr = a;
    #1;
    check(tag, rdat, exp);
    @(negedge clk);
    stb = 0; cyc = 0;
    @(negedge clk);
  endtask

  task automatic wait_pos(int p);
    @(negedge clk);
    while (m_pos != p) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 rgb", {8'd0, rgb}, 32'd0);
    check("R1 hsync", {31'd0, hs_o}, 32'd1);
    check("R1 vsync", {31'd0, vs_o}, 32'd1);
    check("R1 blank", {31'd0, blank}, 32'd1);
    check("R1 ack", {31'd0, ack}, 32'd0);
    rst_n = 1; checking = 1;
    repeat (TOT + 5) @(negedge clk);          // R1 black first frame

    // R6 horizontal stripes in a window
    wb_write(3'd1, {16'd14, 16'd2}, 0);
    wb_write(3'd2, {16'd11, 16'd1}, 0);
    wb_write(3'd3, 32'd3, 0);
    wb_write(3'd4, 32'h00102030, 0);
    wb_write(3'd5, 32'hFF405060, 0);
    wb_write(3'd0, 32'd1, 0);
    // R2 readback, masking and unused address
    wb_read_check(3'd5, 32'h00405060, "R2 base readback");
    wb_read_check(3'd1, {16'd14, 16'd2}, "R2 xwin readback");
    wb_write(3'd6, 32'hDEADBEEF, 0);
    wb_read_check(3'd6, 32'd0, "R2 unused address");
    wb_read_check(3'd0, 32'd1, "R2 ctrl readback");
    repeat (2 * TOT) @(negedge clk);

    // R7 vertical stripes, R11 width 0 and byte wrap
    wb_write(3'd3, 32'd0, 0);
    wb_write(3'd4, 32'h00F0F0F0, 0);
    wb_write(3'd5, 32'h00202020, 0);
    wb_write(3'd0, 32'h3, 0);
    repeat (2 * TOT) @(negedge clk);

    // R8 checkerboard over whole area
    wb_write(3'd1, {16'd16, 16'd0}, 0);
    wb_write(3'd2, {16'd12, 16'd0}, 0);
    wb_write(3'd3, 32'd2, 0);
    wb_write(3'd4, 32'h00808080, 0);
    wb_write(3'd0, 32'h5, 0);
    repeat (2 * TOT) @(negedge clk);

    // R4 R5 write cycle held open across the frame request
    wait_pos(TOT - 2);
    wb_write(3'd0, 32'h1, 1);
    repeat (3) @(negedge clk);
    cyc = 0;
    repeat (2 * TOT) @(negedge clk);

    // R4 R5 strobe exactly on the frame request edge
    wait_pos(TOT - 1);
    wb_write(3'd0, 32'h3, 0);
    repeat (2 * TOT) @(negedge clk);

    // R9 empty window, then disabled
    wb_write(3'd1, {16'd5, 16'd9}, 0);
    repeat (TOT + 10) @(negedge clk);
    wb_write(3'd1, {16'd16, 16'd0}, 0);
    wb_write(3'd0, 32'h0, 0);
    repeat (2 * TOT) @(negedge clk);

    finish_run();
  end
endmodule